// File: doc/BRIEF.md
# Glitch-Free Video Clock Output Gate

This block sits between two free-running video clocks of nominally the same rate and the output pins that carry them off chip. One clock is frequency-spread and the other is not. The two are not phase-locked, so each output lane is gated in its own source clock domain. A single active-low stop pin, which can change at any time, halts both outputs at once. A per-lane enable bit, normally set from a configuration register whose reset value is 1, can hold one output off independently of the pin.

Each lane combines the pin with its own enable and passes the result through a synchronizer clocked on the falling edge of that lane's source clock. The last stage of the synchronizer drives an AND with the source clock. Because the enable only changes while the source is low, the output is either a whole source high phase or nothing. When stopped, an output rests low. When released, an output picks up again on a source rising edge. Lane 0 carries the spread clock and lane 1 carries the non-spread clock.

Top module: `vclk_gate`

## Requirements
- R1: While rst_ni is low, both gated_clk_o bits are low. They also stay low through the first two falling edges of their own source after rst_ni rises.
- R2: Outside reset, a source high phase appears on a lane's output exactly when the lane request (stop_ni high AND oe_i[k] high) was true at the second-to-last falling edge of that source before the phase begins. After stop_ni goes low, the last high pulse that gets through is the one that starts right after the first falling edge that sees it low.
- R3: Every high pulse on gated_clk_o[k] lasts exactly as long as a source high phase, on stop, on restart and in steady running. During every source low phase the output is low.
- R4: When stop_ni returns high with oe_i[k] set, the first output rising edge is the source rising edge that follows the second sampling falling edge. That is 1.5 source periods, and never more than two, after the first falling edge that sees the pin high.
- R5: While oe_i[k] is 0 (after two falling edges of lane k), gated_clk_o[k] stays low whatever stop_ni does.
- R6: Clearing one lane's enable leaves the other lane running and unchanged. stop_ni acts on both lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset; closes both gates |
| src_clk_i | input | NUM_OUT | Free-running source clocks; bit 0 spread, bit 1 non-spread |
| stop_ni | input | 1 | Asynchronous active-low stop pin shared by all lanes |
| oe_i | input | NUM_OUT | Per-lane enable from configuration, 1 = may run |
| gated_clk_o | output | NUM_OUT | Gated clocks; low whenever stopped |

## Verification
The bench drives a spread source whose low phase alternates in length, so any gate that assumes a fixed period or a shared clock between the lanes shows up as a mismatch against the per-edge model. It measures every output high pulse. A gate that opens or closes while the source is high would produce a short pulse, and a gate that shifts the edge would produce a long one, and either fails the width check. The stop and restart edges are timed exactly: a one-stage synchronizer would cut the last pulse too early, and a three-stage one would restart half a period or more too late. Enable bits are exercised alone and against pin toggles, so a gate that lets the pin override a cleared enable, or that couples the lanes, produces pulses where the rise counters expect none.

// File: rtl/vclk_gate_pkg.sv
`timescale 1ns/1ps
package vclk_gate_pkg;
  localparam int unsigned NUM_VIDEO_CLK   = 2;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  // lane order on the output vector
  localparam int unsigned LANE_SPREAD = 0;
  localparam int unsigned LANE_PLAIN  = 1;
endpackage

// File: rtl/vclk_sync.sv
`timescale 1ns/1ps
// falling-edge synchronizer chain; the last stage is the gate enable
module vclk_sync #(
  parameter int unsigned STAGES = vclk_gate_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/vclk_gate_cell.sv
`timescale 1ns/1ps
// en_i must only change while clk_i is low
module vclk_gate_cell (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  assign clk_o = clk_i & en_i;
endmodule

// File: rtl/vclk_lane.sv
`timescale 1ns/1ps
module vclk_lane #(
  parameter int unsigned SYNC_STAGES = vclk_gate_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_ni,
  input  logic oe_i,
  output logic clk_o
);
  logic req, run;

  assign req = stop_ni & oe_i;

  vclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req),
    .q_o   (run)
  );

  vclk_gate_cell u_cell (
    .clk_i(clk_i),
    .en_i (run),
    .clk_o(clk_o)
  );

  if (SYNC_STAGES == 2) begin : g_chk
    logic [1:0] seen_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              seen_q <= '0;
      else if (seen_q != 2'd2)  seen_q <= seen_q + 2'd1;
    end

    // R1
    reset_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (seen_q != 2'd2) |-> !clk_o);

    // R2
    stop_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ((seen_q == 2'd2) && !$past(stop_ni, 2)) |-> !clk_o);

    // R5
    oe_block_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ((seen_q == 2'd2) && !$past(oe_i, 2)) |-> !clk_o);

    // R4
    pass_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      ((seen_q == 2'd2) && $past(stop_ni, 2) && $past(oe_i, 2)) |-> clk_o);
  end
endmodule

// File: rtl/vclk_gate.sv
`timescale 1ns/1ps
module vclk_gate #(
  parameter int unsigned NUM_OUT     = vclk_gate_pkg::NUM_VIDEO_CLK,
  parameter int unsigned SYNC_STAGES = vclk_gate_pkg::DEF_SYNC_STAGES
) (
  input  logic               rst_ni,
  input  logic [NUM_OUT-1:0] src_clk_i,
  input  logic               stop_ni,
  input  logic [NUM_OUT-1:0] oe_i,
  output logic [NUM_OUT-1:0] gated_clk_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    vclk_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
      .clk_i  (src_clk_i[g]),
      .rst_ni (rst_ni),
      .stop_ni(stop_ni),
      .oe_i   (oe_i[g]),
      .clk_o  (gated_clk_o[g])
    );
  end
endmodule

// File: tb/vclk_gate_test.sv
`timescale 1ns/1ps
module vclk_gate_test;
  logic       rst_n  = 1'b1;
  logic       stop_n = 1'b1;
  logic [1:0] oe     = 2'b11;
  logic [1:0] src_clk = 2'b00;
  logic [1:0] gated;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  int  rises     [2] = '{0, 0};
  real last_rise [2] = '{-1.0, -1.0};

  vclk_gate uut (
    .rst_ni     (rst_n),
    .src_clk_i  (src_clk),
    .stop_ni    (stop_n),
    .oe_i       (oe),
    .gated_clk_o(gated)
  );

  // non-spread lane: 50 MHz, edges on multiples of 10 ns
  initial forever #10 src_clk[1] = ~src_clk[1];

  // spread lane: fixed 10 ns high, low phase alternating 10/12 ns
  initial begin
    bit longlow = 1'b0;
    #5;
    forever begin
      src_clk[0] = 1'b1; #10;
      src_clk[0] = 1'b0; #(longlow ? 12 : 10);
      longlow = ~longlow;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  for (genvar k = 0; k < 2; k++) begin : g_mdl
    bit hist[$] = '{1'b0, 1'b0};

    always @(negedge src_clk[k] or negedge rst_n) begin
      if (!rst_n) hist = '{1'b0, 1'b0};
      else begin
        hist.push_back(stop_n & oe[k]);
        void'(hist.pop_front());
      end
    end

    // high phase: model vs output on every source cycle
    always @(posedge src_clk[k]) begin
      #1;
      if (!rst_n) check("R1", $sformatf("lane%0d in reset", k), int'(gated[k]), 0);
      else        check("R2", $sformatf("lane%0d high phase", k), int'(gated[k]), int'(hist[0]));
    end

    // low phase must be low
    always @(negedge src_clk[k]) begin
      #1;
      check("R3", $sformatf("lane%0d low phase", k), int'(gated[k]), 0);
    end

    always @(posedge gated[k]) begin
      rises[k]++;
      last_rise[k] = $realtime;
    end

    always @(negedge gated[k]) begin
      if (last_rise[k] >= 0.0)
        check("R3", $sformatf("lane%0d pulse width x10ns", k),
              int'(($realtime - last_rise[k]) * 10.0), 100);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    real t1, t_s, t_r;
    #0.5 rst_n = 1'b0;
    #40;
    check("R1", "lane0 during reset", int'(gated[0]), 0);
    check("R1", "lane1 during reset", int'(gated[1]), 0);
    #60;
    check("R1", "no pulses in reset", rises[0] + rises[1], 0);
    rst_n = 1'b1;
    #300;

    // R6: both running
    rises = '{0, 0};
    #200;
    check("R6", "lane1 rises both on", rises[1], 10);
    check("R6", "lane0 running", int'(rises[0] >= 9), 1);

    // R2: stop cuts after second sampling edge
    stop_n = 1'b0;
    @(negedge src_clk[1]); t1 = $realtime;
    #100.5;
    check("R2", "last pass x10ns", int'((last_rise[1] - t1) * 10.0), 100);
    rises = '{0, 0};
    #100;
    check("R2", "stopped rises", rises[0] + rises[1], 0);

    // R4: restart latency
    stop_n = 1'b1;
    @(negedge src_clk[1]); t_s = $realtime;
    @(posedge gated[1]);   t_r = $realtime;
    check("R4", "restart latency x10ns", int'((t_r - t_s) * 10.0), 300);
    check("R4", "within two periods", int'((t_r - t_s) <= 40.0), 1);
    #0.5;

    // R5: lane1 enable cleared, pin toggles
    oe = 2'b01;
    #100;
    rises = '{0, 0};
    for (int i = 0; i < 6; i++) begin
      stop_n = ~stop_n;
      #37;
    end
    stop_n = 1'b1;
    #100;
    check("R5", "lane1 rises oe=0", rises[1], 0);
    check("R5", "lane1 level oe=0", int'(gated[1]), 0);

    // R6: lane0 off, lane1 unaffected
    oe = 2'b10;
    #100;
    rises = '{0, 0};
    #200;
    check("R6", "lane0 rises oe=0", rises[0], 0);
    check("R6", "lane1 rises other off", rises[1], 10);

    // mixed pin/enable activity against the model
    oe = 2'b11;
    for (int i = 0; i < 120; i++) begin
      #($urandom_range(3, 60));
      if ($urandom_range(0, 3) == 0) oe = 2'($urandom_range(0, 3));
      else                           stop_n = ~stop_n;
    end
    stop_n = 1'b1;
    oe = 2'b11;
    #200;
    finish_run();
  end
endmodule